// File: doc/BRIEF.md
# Pause Frame Flow Control Scheduler

This block decides when a transmit MAC emits pause control frames and which timer value each one carries. Software supplies a 16-bit pause time, a 16-bit repeat interval, a global enable for transmit flow control, and a flow-control request bit that it writes through a strobe. A one-cycle slot tick marks each 512-bit-time slot. The block raises a frame request with a timer value and holds both until the transmitter answers with a one-cycle done pulse.

With a non-zero repeat interval, the block keeps the far end paused. It re-sends the pause time each time its slot counter reaches the interval. When software withdraws the request, it sends one closing frame with time zero. With a zero interval it sends a single frame, counts slots up to the pause time, and then clears the request bit itself so that software can poll for completion. The slot counter is exposed for status readout.

The controller has four states. IDLE goes to SEND_ON when the enable and the request bit are both set. SEND_ON goes to HOLD on done. HOLD goes to IDLE when the enable drops, or when the request is withdrawn in single-shot mode, or when the single-shot count expires (this also clears the request bit). HOLD goes to SEND_OFF when the request is withdrawn in repeat mode, and back to SEND_ON when the repeat interval is reached. SEND_OFF goes to IDLE on done.

Top module: `pause_sched`

## Requirements
- R1: After reset `frame_req` is 0, `req_bit` is 0 and `status_cnt` is 0.
- R2: With `fc_en`=1 and `req_bit`=1 while idle, `frame_req` rises with `frame_time` equal to `pause_val`. Both hold steady until a cycle with `frame_done`=1.
- R3: The done pulse of any frame resets `status_cnt` to 0. After that, each `slot_tick` adds one, saturating at 0xFFFF. Ticks while `frame_req`=1 leave `status_cnt` unchanged.
- R4: In repeat mode (`mirror_val`≠0), a new frame carrying `pause_val` is requested once `status_cnt` reaches `mirror_val`. No frame is requested before that.
- R5: In repeat mode, clearing `req_bit` produces exactly one frame with `frame_time`=0x0000, after which the block stays idle.
- R6: In single-shot mode (`mirror_val`=0), no further frame follows the first. One cycle after `status_cnt` reaches `pause_val`, `req_bit` reads 0.
- R7: While `fc_en`=0, no frame is requested, even with `req_bit`=1.
- R8: A change of `mirror_val` during a pause takes effect at once. Changing it from zero to a value at or below the current count causes a repeat frame.
- R9: If `req_bit` is cleared while a repeat-mode frame is pending, that frame keeps its time value until done, and the zero-time frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_en | input | 1 | Global transmit flow-control enable |
| req_wr | input | 1 | Write strobe for the request bit |
| req_wdata | input | 1 | Value written to the request bit |
| pause_val | input | 16 | Pause time placed in pause frames, in slots |
| mirror_val | input | 16 | Repeat interval in slots; 0 selects single-shot mode |
| slot_tick | input | 1 | One-cycle pulse per 512-bit-time slot |
| frame_done | input | 1 | Transmitter done pulse for the pending frame |
| frame_req | output | 1 | Pause frame request |
| frame_time | output | 16 | Timer value for the requested frame |
| req_bit | output | 1 | Current flow-control request bit |
| status_cnt | output | 16 | Slot counter since the last sent frame |

## Verification
The assertions assume that `frame_done` is a single-cycle pulse given only while `frame_req` is high, as a well-behaved transmitter would do. The bench raises done only after it has seen `frame_req` at a falling edge, and drops it one cycle later. Writes to the request bit and changes to the pause and repeat values are applied on falling edges, one at a time. Each scenario begins from reset, so every counter expectation starts from zero.

// File: rtl/pause_sched_pkg.sv
package pause_sched_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND_ON,
        ST_HOLD,
        ST_SEND_OFF
    } fc_state_e;
endpackage

// File: rtl/pause_req_bit.sv
module pause_req_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wdata,
    input  logic self_clr,
    output logic bit_q
);
    // software write wins over the self-clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_q <= 1'b0;
        else if (wr)
            bit_q <= wdata;
        else if (self_clr)
            bit_q <= 1'b0;
    end
endmodule

// File: rtl/pause_slot_counter.sv
module pause_slot_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic         tick,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (run && tick && cnt != MAXV)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pause_fsm.sv
module pause_fsm
    import pause_sched_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fc_en,
    input  logic         req_bit,
    input  logic [W-1:0] pause_val,
    input  logic [W-1:0] mirror_val,
    input  logic [W-1:0] cnt,
    input  logic         done,
    output logic         frame_req,
    output logic [W-1:0] frame_time,
    output logic         cnt_clr,
    output logic         cnt_run,
    output logic         self_clr
);
    fc_state_e    state, state_nx;
    logic [W-1:0] time_q;
    logic         repeat_mode;
    logic         single_expired;

    assign repeat_mode    = (mirror_val != '0);
    assign single_expired = !repeat_mode && (cnt >= pause_val);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (fc_en && req_bit)
                    state_nx = ST_SEND_ON;
            end
            ST_SEND_ON: begin
                if (done)
                    state_nx = ST_HOLD;
            end
            ST_HOLD: begin
                if (!fc_en)
                    state_nx = ST_IDLE;
                else if (!req_bit)
                    state_nx = repeat_mode ? ST_SEND_OFF : ST_IDLE;
                else if (repeat_mode && cnt >= mirror_val)
                    state_nx = ST_SEND_ON;
                else if (single_expired)
                    state_nx = ST_IDLE;
            end
            ST_SEND_OFF: begin
                if (done)
                    state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            time_q <= '0;
        end else begin
            state <= state_nx;
            if (state_nx == ST_SEND_ON && state != ST_SEND_ON)
                time_q <= pause_val;
        end
    end

    always_comb begin
        frame_req  = 1'b0;
        frame_time = '0;
        cnt_clr    = 1'b0;
        cnt_run    = 1'b0;
        self_clr   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_SEND_ON: begin
                frame_req  = 1'b1;
                frame_time = time_q;
                cnt_clr    = done;
            end
            ST_HOLD: begin
                cnt_run  = 1'b1;
                self_clr = fc_en && req_bit && single_expired;
            end
            ST_SEND_OFF: begin
                frame_req = 1'b1;
                cnt_clr   = done;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pause_sched.sv
module pause_sched #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fc_en,
    input  logic          req_wr,
    input  logic          req_wdata,
    input  logic [TW-1:0] pause_val,
    input  logic [TW-1:0] mirror_val,
    input  logic          slot_tick,
    input  logic          frame_done,
    output logic          frame_req,
    output logic [TW-1:0] frame_time,
    output logic          req_bit,
    output logic [TW-1:0] status_cnt
);
    logic cnt_clr, cnt_run, self_clr;

    pause_req_bit u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (req_wr),
        .wdata    (req_wdata),
        .self_clr (self_clr),
        .bit_q    (req_bit)
    );

    pause_slot_counter #(.W(TW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .run   (cnt_run),
        .tick  (slot_tick),
        .cnt   (status_cnt)
    );

    pause_fsm #(.W(TW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fc_en      (fc_en),
        .req_bit    (req_bit),
        .pause_val  (pause_val),
        .mirror_val (mirror_val),
        .cnt        (status_cnt),
        .done       (frame_done),
        .frame_req  (frame_req),
        .frame_time (frame_time),
        .cnt_clr    (cnt_clr),
        .cnt_run    (cnt_run),
        .self_clr   (self_clr)
    );
endmodule

// File: rtl/pause_sched_chk.sv
module pause_sched_chk #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fc_en,
    input logic          frame_done,
    input logic          frame_req,
    input logic [TW-1:0] frame_time,
    input logic [TW-1:0] status_cnt
);
    localparam logic [TW-1:0] MAXV = {TW{1'b1}};

    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        frame_req && !frame_done |=> frame_req && $stable(frame_time));

    a_r3_tick_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        frame_req && !frame_done |=> $stable(status_cnt));

    a_r3_clear_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        frame_req && frame_done |=> status_cnt == '0);

    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        status_cnt == MAXV && !frame_done |=> status_cnt == MAXV);

    a_r7_quiet_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_en && !frame_req |=> !frame_req);
endmodule

bind pause_sched pause_sched_chk #(.TW(TW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fc_en      (fc_en),
    .frame_done (frame_done),
    .frame_req  (frame_req),
    .frame_time (frame_time),
    .status_cnt (status_cnt)
);

// File: tb/pause_sched_test.sv
module pause_sched_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fc_en = 1'b0;
    logic        req_wr = 1'b0;
    logic        req_wdata = 1'b0;
    logic [15:0] pause_val = '0;
    logic [15:0] mirror_val = '0;
    logic        slot_tick = 1'b0;
    logic        frame_done = 1'b0;
    logic        frame_req;
    logic [15:0] frame_time;
    logic        req_bit;
    logic [15:0] status_cnt;

    int total = 0;
    int bad = 0;
    bit ended = 0;

    always #5 clk = ~clk;

    pause_sched uut (
        .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .req_wr(req_wr),
        .req_wdata(req_wdata), .pause_val(pause_val), .mirror_val(mirror_val),
        .slot_tick(slot_tick), .frame_done(frame_done), .frame_req(frame_req),
        .frame_time(frame_time), .req_bit(req_bit), .status_cnt(status_cnt)
    );

    // rows: {pause_val, mirror_val}
    localparam logic [31:0] VEC [5] = '{
        {16'd20, 16'd15},
        {16'd8,  16'd3},
        {16'd4,  16'd1},
        {16'd6,  16'd0},
        {16'd3,  16'd0}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fc_en = 1'b1; req_wr = 1'b0; slot_tick = 1'b0; frame_done = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic sw_req(input bit v);
        @(negedge clk);
        req_wr = 1'b1; req_wdata = v;
        @(negedge clk);
        req_wr = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            slot_tick = 1'b1;
            @(negedge clk);
            slot_tick = 1'b0;
        end
    endtask

    task automatic wait_frame(input int maxc, output bit found);
        found = 0;
        for (int i = 0; i < maxc && !found; i++) begin
            @(negedge clk);
            if (frame_req) found = 1;
        end
    endtask

    task automatic finish_frame();
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
    endtask

    task automatic quiet(input int n, input string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (frame_req) seen++;
        end
        check(seen == 0, tag, seen, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++; bad++;
            $display("FAIL watchdog act=1 exp=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        bit f;
        logic [15:0] p, m;

        // R1 reset state
        do_reset();
        @(negedge clk);
        check(frame_req == 0, "R1 frame_req", frame_req, 0);
        check(req_bit == 0, "R1 req_bit", req_bit, 0);
        check(status_cnt == 0, "R1 status", status_cnt, 0);

        for (int v = 0; v < 5; v++) begin
            p = VEC[v][31:16];
            m = VEC[v][15:0];
            do_reset();
            pause_val = p; mirror_val = m;
            sw_req(1'b1);
            wait_frame(4, f);
            check(f && frame_time == p, "R2 first frame", frame_time, p);
            repeat (3) @(negedge clk);
            check(frame_req && frame_time == p, "R2 held until done", frame_time, p);
            pause_val = p + 16'd7;   // later change must not disturb the pending frame
            @(negedge clk);
            check(frame_time == p, "R2 stable time", frame_time, p);
            pause_val = p;
            finish_frame();
            check(status_cnt == 0 && !frame_req, "R3 clear on done", status_cnt, 0);
            if (m != 0) begin
                tick(m - 1);
                check(status_cnt == m - 1, "R3 count ticks", status_cnt, m - 1);
                check(!frame_req, "R4 no early frame", frame_req, 0);
                tick(1);
                wait_frame(3, f);
                check(f && frame_time == p, "R4 repeat frame", frame_time, p);
                tick(2);
                check(status_cnt == m, "R3 ticks ignored while pending", status_cnt, m);
                finish_frame();
                check(status_cnt == 0, "R3 restart", status_cnt, 0);
                sw_req(1'b0);
                wait_frame(4, f);
                check(f && frame_time == 0, "R5 zero frame", frame_time, 0);
                finish_frame();
                quiet(2 * m + 6, "R5 idle after zero frame");
            end else begin
                tick(p - 1);
                check(req_bit == 1 && !frame_req, "R6 still pausing", req_bit, 1);
                tick(1);
                @(negedge clk);
                check(req_bit == 0, "R6 self clear", req_bit, 0);
                check(status_cnt == p, "R3 status at end", status_cnt, p);
                tick(3);
                quiet(4, "R6 single frame only");
            end
        end

        // R7 disabled: no frames despite request
        do_reset();
        fc_en = 1'b0; pause_val = 16'd10; mirror_val = 16'd4;
        sw_req(1'b1);
        quiet(10, "R7 disabled");
        check(req_bit == 1, "R7 request kept", req_bit, 1);
        fc_en = 1'b1;
        wait_frame(4, f);
        check(f && frame_time == 10, "R7 enable releases", frame_time, 10);

        // R8 switch single-shot -> repeat mid-pause
        do_reset();
        pause_val = 16'd30; mirror_val = 16'd0;
        sw_req(1'b1);
        wait_frame(4, f);
        finish_frame();
        tick(5);
        quiet(4, "R8 no frame in single mode");
        mirror_val = 16'd2;
        wait_frame(4, f);
        check(f && frame_time == 30, "R8 switch to repeat", frame_time, 30);
        finish_frame();
        mirror_val = 16'd0;
        tick(29);
        check(req_bit == 1, "R8 back to single", req_bit, 1);
        tick(1);
        @(negedge clk);
        check(req_bit == 0, "R8 single expiry", req_bit, 0);

        // R9 withdraw while pending
        do_reset();
        pause_val = 16'h1234; mirror_val = 16'd5;
        sw_req(1'b1);
        wait_frame(4, f);
        sw_req(1'b0);
        check(frame_req && frame_time == 16'h1234, "R9 pending kept", frame_time, 16'h1234);
        finish_frame();
        wait_frame(4, f);
        check(f && frame_time == 0, "R9 zero after pending", frame_time, 0);
        finish_frame();
        quiet(12, "R9 idle");

        // R1 reset mid-pause
        sw_req(1'b1);
        wait_frame(4, f);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(!frame_req && req_bit == 0 && status_cnt == 0, "R1 mid reset", req_bit, 0);

        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule